// File: doc/BRIEF.md
# UART Interrupt Cause and Status Word

This block collects every interrupt cause of a high-speed serial port into one 32-bit status word. A host reads it and clears the causes it has serviced. Five event sources feed it:
- line errors,
- received data available,
- receive character timeout,
- transmit space available,
- a change on any of the four modem input lines.

Each source latches a cause flag. The flag stays set until the host writes a one to it. Several causes can be pending together.

The same word also passes the receiver's line status byte and the receive fill count straight through, next to the modem byte. So one read gives the host a full picture of the port. A single interrupt request line is the OR of the pending causes, each gated by its enable bit from the configuration register. The modem inputs are asynchronous. Each goes through a two-flop synchronizer, and a delta flag is raised on any edge of it.

Top module: `uart_irq_status`

## Requirements
- R1: Cause flags sit in status bits [4:0]: bit 0 line error, bit 1 receive data available, bit 2 character timeout, bit 3 transmit space, bit 4 modem change. An input that is high at a clock edge sets its flag, which is visible after that edge. The flag holds until it is cleared.
- R2: Status bits [15:8] carry the modem byte. Bits 8..11 are the delta flags for CTS, DSR, RI and DCD (`modem_in[0..3]`). Bits 12..15 are the synchronized live levels of the same lines. A level shows two clock edges after the input changes.
- R3: Status bits [23:16] carry `line_stat` unchanged, and status bit 5 always reads 0.
- R4: The 10-bit receive fill count is split. Count bits [9:8] appear in status bits [7:6], and count bits [7:0] appear in status bits [31:24].
- R5: A write with `bus_wr`=1, `bus_addr`=0 and `bus_be[0]`=1 clears every cause flag whose bit in `bus_wdata[4:0]` is 1, and leaves the others alone. A write with `bus_be[0]`=0, or to any other address, changes no flag.
- R6: A clear write leaves status bits [7:6] and the other pass-through fields unchanged.
- R7: `irq` is high when any of these holds: cause 0 with enable bit 2, cause 1 or 2 with enable bit 0, cause 3 with enable bit 1, or cause 4 with enable bit 3. Flags still latch while their enable is 0.
- R8: If a cause event and a clear of that bit arrive in the same cycle, the flag stays set.
- R9: A rising or a falling edge on a modem line sets that line's delta flag and cause bit 4, one edge after the synchronized level changes. Clearing cause bit 4 also clears all four delta flags.
- R10: After reset every cause flag, delta flag and live level is 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_line_err | input | 1 | Receiver line error event |
| ev_rx_avail | input | 1 | Receive data available event |
| ev_char_tmo | input | 1 | Character timeout event |
| ev_tx_space | input | 1 | Transmit space available event |
| modem_in | input | 4 | Asynchronous CTS, DSR, RI, DCD levels (bits 0..3) |
| cfg_en | input | 4 | Enables: 0 receive, 1 transmit, 2 line status, 3 modem |
| line_stat | input | 8 | Line status byte |
| rx_fill | input | 10 | Receive FIFO fill count |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables |
| status_word | output | 32 | Assembled status word |
| irq | output | 1 | Interrupt request |

## Verification
A table walks each cause source with enable patterns that either include or exclude the matching enable bit. This separates a wrong cause-to-enable pairing from a flag that fails to latch while its interrupt is masked.

Directed cases cover:
- clearing a subset of the flags, to show the clear is bitwise and not global;
- writes with the wrong byte enable or address, which must leave the flags alone;
- a clear colliding with a new event on the same bit;
- a fill count whose two high bits are non-zero, checked across a clear write.

Modem lines are toggled up and then down, to show that both edges register and that the synchronizer delay is exactly two cycles.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    localparam int NCAUSE  = 5;
    localparam int NMODEM  = 4;
    localparam int FILL_W  = 10;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 32;

    localparam int C_LINE  = 0;
    localparam int C_RXD   = 1;
    localparam int C_TMO   = 2;
    localparam int C_TXS   = 3;
    localparam int C_MDM   = 4;

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;
endpackage

// File: rtl/uirq_edge_sync.sv
module uirq_edge_sync
    import uirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic edge_o
);
    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = async_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.s2;
    assign edge_o  = st_q.s2 ^ st_q.prev;
endmodule

// File: rtl/uirq_flag_bank.sv
module uirq_flag_bank #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] flags;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d       = bk_q;
        bk_d.flags = (bk_q.flags & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign q_o = bk_q.flags;
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uirq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ev_line_err,
    input  logic                 ev_rx_avail,
    input  logic                 ev_char_tmo,
    input  logic                 ev_tx_space,
    input  logic [NMODEM-1:0]    modem_in,
    input  logic [3:0]           cfg_en,
    input  logic [BYTE_W-1:0]    line_stat,
    input  logic [FILL_W-1:0]    rx_fill,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    input  logic [3:0]           bus_be,
    output logic [WORD_W-1:0]    status_word,
    output logic                 irq
);
    logic [NMODEM-1:0] live_lvl, live_edge, delta_q;
    logic [NCAUSE-1:0] cause_set, cause_clr, cause_q, en_map;
    logic              clr_hit;

    for (genvar g = 0; g < NMODEM; g++) begin : g_sync
        uirq_edge_sync u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (modem_in[g]),
            .level_o (live_lvl[g]),
            .edge_o  (live_edge[g])
        );
    end

    always_comb begin
        clr_hit            = bus_wr && (bus_addr == '0) && bus_be[0];
        cause_clr          = clr_hit ? bus_wdata[NCAUSE-1:0] : '0;
        cause_set          = '0;
        cause_set[C_LINE]  = ev_line_err;
        cause_set[C_RXD]   = ev_rx_avail;
        cause_set[C_TMO]   = ev_char_tmo;
        cause_set[C_TXS]   = ev_tx_space;
        cause_set[C_MDM]   = |live_edge;
        en_map[C_LINE]     = cfg_en[2];
        en_map[C_RXD]      = cfg_en[0];
        en_map[C_TMO]      = cfg_en[0];
        en_map[C_TXS]      = cfg_en[1];
        en_map[C_MDM]      = cfg_en[3];
    end

    uirq_flag_bank #(.W(NCAUSE)) u_cause (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (cause_set),
        .clr_i (cause_clr),
        .q_o   (cause_q)
    );

    uirq_flag_bank #(.W(NMODEM)) u_delta (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (live_edge),
        .clr_i ({NMODEM{cause_clr[C_MDM]}}),
        .q_o   (delta_q)
    );

    always_comb begin
        status_word        = '0;
        status_word[4:0]   = cause_q;
        status_word[7:6]   = rx_fill[9:8];
        status_word[15:8]  = {live_lvl, delta_q};
        status_word[23:16] = line_stat;
        status_word[31:24] = rx_fill[7:0];
        irq                = |(cause_q & en_map);
    end
endmodule

// File: rtl/uirq_checker.sv
module uirq_checker #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [3:0]        bus_be,
    input logic [31:0]       bus_wdata,
    input logic              ev_rx_avail,
    input logic              ev_line_err,
    input logic [3:0]        cfg_en,
    input logic [31:0]       status_word,
    input logic              irq
);
    logic clr_ok;
    assign clr_ok = bus_wr && (bus_addr == '0) && bus_be[0];

    AST_CLEAR_RXD: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ok && bus_wdata[1] && !ev_rx_avail) |=> !status_word[1]); // R5

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ok && bus_wdata[1] && ev_rx_avail) |=> status_word[1]); // R8

    AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[0] && !(clr_ok && bus_wdata[0])) |=> status_word[0]); // R1

    AST_LINE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_line_err |=> status_word[0]); // R1

    AST_NO_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_word[4:0] == 5'd0) || (cfg_en == 4'd0)) |-> !irq); // R7

    AST_DELTA_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[11:8] != 4'd0) |-> status_word[4]); // R9

    AST_BIT5_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !status_word[5]); // R3
endmodule

bind uart_irq_status uirq_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_be      (bus_be),
    .bus_wdata   (bus_wdata),
    .ev_rx_avail (ev_rx_avail),
    .ev_line_err (ev_line_err),
    .cfg_en      (cfg_en),
    .status_word (status_word),
    .irq         (irq)
);

// File: tb/sim_uart_irq_status.sv
`timescale 1ns/1ps
module sim_uart_irq_status;
    localparam int ADDR_W = 12;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        ev_line_err = 0, ev_rx_avail = 0, ev_char_tmo = 0, ev_tx_space = 0;
    logic [3:0]  modem_in = 0;
    logic [3:0]  cfg_en = 0;
    logic [7:0]  line_stat = 0;
    logic [9:0]  rx_fill = 0;
    logic        bus_wr = 0;
    logic [ADDR_W-1:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [3:0]  bus_be = 0;
    logic [31:0] status_word;
    logic        irq;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    uart_irq_status #(.ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .ev_line_err(ev_line_err), .ev_rx_avail(ev_rx_avail),
        .ev_char_tmo(ev_char_tmo), .ev_tx_space(ev_tx_space),
        .modem_in(modem_in), .cfg_en(cfg_en), .line_stat(line_stat),
        .rx_fill(rx_fill), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be),
        .status_word(status_word), .irq(irq)
    );

    // entry: {events {tx,tmo,rx,line}, cfg_en, expected irq}
    localparam int NVEC = 8;
    localparam logic [8:0] VEC [NVEC] = '{
        {4'b0001, 4'b0100, 1'b1},
        {4'b0001, 4'b1011, 1'b0},
        {4'b0010, 4'b0001, 1'b1},
        {4'b0100, 4'b0001, 1'b1},
        {4'b0100, 4'b1110, 1'b0},
        {4'b1000, 4'b0010, 1'b1},
        {4'b1000, 4'b1101, 1'b0},
        {4'b1111, 4'b0000, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [3:0] be, input logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_be = be; bus_wdata = d;
        tick();
        bus_wr = 0; bus_addr = 0; bus_be = 0; bus_wdata = 0;
    endtask

    task automatic pulse(input logic [3:0] ev);
        {ev_tx_space, ev_char_tmo, ev_rx_avail, ev_line_err} = ev;
        tick();
        {ev_tx_space, ev_char_tmo, ev_rx_avail, ev_line_err} = 4'b0;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset word", status_word, 32'h0);
        chk("R10 reset irq", {31'b0, irq}, 32'h0);
        rst_n = 1;
        tick();

        // R1 R7 table walk
        for (int i = 0; i < NVEC; i++) begin
            wr('0, 4'b0001, 32'h1F);
            cfg_en = VEC[i][4:1];
            pulse(VEC[i][8:5]);
            chk("R1 cause latch", {27'b0, status_word[4:0]}, {28'b0, VEC[i][8:5]});
            chk("R7 irq gating", {31'b0, irq}, {31'b0, VEC[i][0]});
        end
        cfg_en = 0;

        // R3 R4 pass-through
        line_stat = 8'hA5; rx_fill = 10'h2C3;
        #1;
        chk("R3 line byte", {24'b0, status_word[23:16]}, 32'hA5);
        chk("R4 fill split", {22'b0, status_word[7:6], status_word[31:24]}, 32'h2C3);

        // R5 partial clear: flags 1111 set from table end, clear bit1
        wr('0, 4'b0001, 32'h02);
        chk("R5 partial clear", {27'b0, status_word[4:0]}, 32'h0D);
        chk("R6 fill bits kept", {30'b0, status_word[7:6]}, 32'h2);
        wr('0, 4'b0000, 32'h1F);
        chk("R5 be0 ignored", {27'b0, status_word[4:0]}, 32'h0D);
        wr(12'h004, 4'b0001, 32'h1F);
        chk("R5 addr ignored", {27'b0, status_word[4:0]}, 32'h0D);
        chk("R6 line byte kept", {24'b0, status_word[23:16]}, 32'hA5);

        // R8 set wins over clear
        ev_rx_avail = 1;
        wr('0, 4'b0001, 32'h1F);
        ev_rx_avail = 0;
        chk("R8 set wins", {27'b0, status_word[4:0]}, 32'h02);
        wr('0, 4'b0001, 32'h1F);
        chk("R5 full clear", {27'b0, status_word[4:0]}, 32'h0);

        // R2 R9 modem rise on CTS
        line_stat = 0; rx_fill = 0; cfg_en = 4'b1000;
        modem_in = 4'b0001;
        tick(); tick();
        chk("R2 live after two edges", {16'b0, status_word[15:0]}, 32'h1000);
        tick();
        chk("R9 delta on rise", {16'b0, status_word[15:0]}, 32'h1110);
        chk("R7 modem irq", {31'b0, irq}, 32'h1);
        wr('0, 4'b0001, 32'h10);
        chk("R9 clear deltas", {16'b0, status_word[15:0]}, 32'h1000);
        // falling edge on CTS, rising on DCD
        modem_in = 4'b1000;
        tick(); tick(); tick();
        chk("R9 both edges", {16'b0, status_word[15:0]}, 32'h8910);
        wr('0, 4'b0001, 32'h10);
        chk("R2 DCD live only", {16'b0, status_word[15:0]}, 32'h8000);
        chk("R7 no irq after clear", {31'b0, irq}, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule